// File: doc/BRIEF.md
# Endian-Configurable Byte-Addressed Data Memory

This block is the data store of a 32-bit load/store core. Every location is named by a byte address, yet storage is held as aligned 32-bit words split into four byte lanes. A single request port carries a byte address, a store/load strobe, an access size (byte, halfword or word), write data and a flag that picks sign or zero extension for narrow loads. Loads return their value one clock after the request.

A static input chooses how the bytes of a multi-byte value are laid out across increasing addresses: with big-endian placement the most significant byte goes to the lowest address, and with little-endian placement the least significant byte does. Narrow stores write only the byte lanes they cover. An access whose address is not a multiple of its size raises an error flag, and a store raised in this way changes nothing.

Top module: `endian_dmem`

## Requirements
- R1: While reset is held and in the first cycle after it, `rdata_o` and `err_o` are both zero.
- R2: A word (size code 2'b10) loaded from an aligned address returns the word last stored there with the same endianness setting.
- R3: With `big_endian_i`=1, storing word 0x87654321 at byte address A (A a multiple of 4) makes unsigned byte loads at A, A+1, A+2, A+3 return 0x87, 0x65, 0x43, 0x21.
- R4: With `big_endian_i`=0, the same store makes those byte loads return 0x21, 0x43, 0x65, 0x87.
- R5: A byte store (size code 2'b00) alters only the byte at its address; the other three bytes of that word keep their values.
- R6: A halfword store (size code 2'b01) writes the two bytes at A and A+1 in the order set by the endianness input and leaves the other two bytes of the word unchanged; a halfword load reads them back in the same order.
- R7: A halfword access with `addr_i[0]`=1, a word access with `addr_i[1:0]`≠0, or any access with the reserved size code 2'b11 sets `err_o` to 1 in the cycle after the request; every other cycle `err_o` is 0.
- R8: A store flagged under R7 leaves memory unchanged, and a load flagged under R7 returns 0 on `rdata_o`.
- R9: With `ld_signed_i`=1, a byte or halfword load copies the loaded value's top bit into all higher bits of `rdata_o`.
- R10: With `ld_signed_i`=0, a byte or halfword load fills all higher bits of `rdata_o` with zeros.
- R11: Load data appears on `rdata_o` one cycle after the request and holds until the next load request; stores and idle cycles do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | 1: most significant byte at lowest address; 0: least significant byte at lowest address |
| req_i | input | 1 | Access request strobe |
| wr_i | input | 1 | 1: store, 0: load |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Store value, right-aligned for narrow sizes |
| size_i | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| ld_signed_i | input | 1 | 1: sign-extend narrow loads; 0: zero-extend |
| rdata_o | output | 32 | Extended load value |
| err_o | output | 1 | Misaligned or reserved-size access, one cycle after request |

## Verification
A wrong lane mapping or byte-enable in this block stays hidden until the affected word is read back, so each store in the sweep is followed at once by a load of the same size and a full-word load of the same word; a misplaced or stray byte then shows on `rdata_o` within two requests. Faults in the extension logic or in the error path show in the very next cycle after the request, since both results are registered exactly once. Holding of `rdata_o` across stores is checked by reading it after non-load cycles.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_B   = 2'b00,
    SZ_H   = 2'b01,
    SZ_W   = 2'b10,
    SZ_RSV = 2'b11
  } acc_size_e;

  // number of bytes moved by a size code; zero for the reserved code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      2'b10:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // true when the offset is not a multiple of the access size
  function automatic logic bad_access(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      2'b00:   return 1'b0;
      2'b01:   return off[0];
      2'b10:   return |off;
      default: return 1'b1;
    endcase
  endfunction

  // physical lane holding value byte k (k=0 is least significant)
  function automatic logic [1:0] lane_of(input logic [1:0] off, input logic [2:0] nb,
                                         input logic [1:0] k, input logic big);
    logic [2:0] pos;
    if (big) pos = {1'b0, off} + nb - 3'd1 - {1'b0, k};
    else     pos = {1'b0, off} + {1'b0, k};
    return pos[1:0];
  endfunction

  // widen a right-aligned narrow value to 32 bits
  function automatic logic [31:0] extend_load(input logic [31:0] raw, input logic [1:0] sz,
                                              input logic sgn);
    case (sz)
      2'b00:   return {{24{sgn & raw[7]}}, raw[7:0]};
      2'b01:   return {{16{sgn & raw[15]}}, raw[15:0]};
      default: return raw;
    endcase
  endfunction

endpackage

// File: rtl/dmem_store_steer.sv
module dmem_store_steer
  import dmem_pkg::*;
(
  input  logic [1:0]         size_i,
  input  logic [1:0]         off_i,
  input  logic               big_i,
  input  logic [8*LANES-1:0] wdata_i,
  output logic [LANES-1:0]   be_o,
  output logic [8*LANES-1:0] data_o
);

  logic [2:0] nb;
  assign nb = size_bytes(size_i);

  always_comb begin
    logic [1:0] ln;
    be_o   = '0;
    data_o = '0;
    ln     = '0;
    for (int k = 0; k < LANES; k++) begin
      if (3'(k) < nb) begin
        ln              = lane_of(off_i, nb, 2'(k), big_i);
        be_o[ln]        = 1'b1;
        data_o[8*ln +: 8] = wdata_i[8*k +: 8];
      end
    end
  end

endmodule

// File: rtl/dmem_load_extract.sv
module dmem_load_extract
  import dmem_pkg::*;
(
  input  logic [8*LANES-1:0] raw_i,
  input  logic [1:0]         size_i,
  input  logic [1:0]         off_i,
  input  logic               big_i,
  input  logic               sgn_i,
  output logic [31:0]        value_o
);

  logic [2:0]  nb;
  logic [31:0] gathered;
  assign nb = size_bytes(size_i);

  always_comb begin
    logic [1:0] ln;
    gathered = '0;
    ln       = '0;
    for (int k = 0; k < LANES; k++) begin
      if (3'(k) < nb) begin
        ln                  = lane_of(off_i, nb, 2'(k), big_i);
        gathered[8*k +: 8]  = raw_i[8*ln +: 8];
      end
    end
  end

  assign value_o = extend_load(gathered, size_i, sgn_i);

endmodule

// File: rtl/dmem_bank.sv
module dmem_bank
  import dmem_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [LANES-1:0]   be_i,
  input  logic [8*LANES-1:0] wdata_i,
  input  logic               re_i,
  output logic [8*LANES-1:0] rword_o
);

  localparam int WORDS = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] cells [WORDS];
    logic [7:0] rd_q;

    always_ff @(posedge clk) begin
      if (be_i[g]) cells[idx_i] <= wdata_i[8*g +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rd_q <= '0;
      else if (re_i) rd_q <= cells[idx_i];
    end

    assign rword_o[8*g +: 8] = rd_q;
  end

endmodule

// File: rtl/endian_dmem.sv
module endian_dmem
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian_i,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [1:0]        size_i,
  input  logic              ld_signed_i,
  output logic [31:0]       rdata_o,
  output logic              err_o
);

  localparam int IDX_W = ADDR_W - 2;

  // request decode, brought out as named events
  logic [1:0]       off_c;
  logic [IDX_W-1:0] idx_c;
  logic             bad_c;
  logic             st_fire;
  logic             ld_fire;
  logic             ld_bad;

  assign off_c   = addr_i[1:0];
  assign idx_c   = addr_i[ADDR_W-1:2];
  assign bad_c   = bad_access(size_i, off_c);
  assign st_fire = req_i &  wr_i & ~bad_c;
  assign ld_fire = req_i & ~wr_i & ~bad_c;
  assign ld_bad  = req_i & ~wr_i &  bad_c;

  // store steering
  logic [LANES-1:0]   steer_be;
  logic [8*LANES-1:0] steer_data;
  logic [LANES-1:0]   bank_be;

  dmem_store_steer u_steer (
    .size_i  (size_i),
    .off_i   (off_c),
    .big_i   (big_endian_i),
    .wdata_i (wdata_i),
    .be_o    (steer_be),
    .data_o  (steer_data)
  );

  assign bank_be = st_fire ? steer_be : '0;

  // storage with registered read word
  logic [8*LANES-1:0] rword;

  dmem_bank #(.IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_i   (idx_c),
    .be_i    (bank_be),
    .wdata_i (steer_data),
    .re_i    (ld_fire),
    .rword_o (rword)
  );

  // load attributes captured alongside the read word
  logic [1:0] m_size;
  logic [1:0] m_off;
  logic       m_big;
  logic       m_sgn;
  logic       zero_q;
  logic       err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_size <= SZ_B;
      m_off  <= '0;
      m_big  <= 1'b0;
      m_sgn  <= 1'b0;
      zero_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= req_i & bad_c;
      if (ld_fire) begin
        m_size <= size_i;
        m_off  <= off_c;
        m_big  <= big_endian_i;
        m_sgn  <= ld_signed_i;
        zero_q <= 1'b0;
      end else if (ld_bad) begin
        zero_q <= 1'b1;
      end
    end
  end

  logic [31:0] ld_value;

  dmem_load_extract u_extract (
    .raw_i   (rword),
    .size_i  (m_size),
    .off_i   (m_off),
    .big_i   (m_big),
    .sgn_i   (m_sgn),
    .value_o (ld_value)
  );

  assign rdata_o = zero_q ? 32'd0 : ld_value;
  assign err_o   = err_q;

  // R8
  bad_store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && wr_i && bad_c) |-> (bank_be == '0));

  // R5
  byte_lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && size_i == SZ_B) |-> ($countones(bank_be) == 1));

  // R6
  half_lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fire && size_i == SZ_H) |-> ($countones(bank_be) == 2));

  // R7
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && bad_c) |=> err_o);

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_i) |=> !err_o);

  // R10
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && !ld_signed_i && size_i == SZ_B) |=> (rdata_o[31:8] == 24'd0));

  // R9
  half_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && ld_signed_i && size_i == SZ_H) |=> (rdata_o[31:16] == {16{rdata_o[15]}}));

  // R8
  bad_load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_bad |=> (rdata_o == 32'd0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_i && !wr_i) |=> $stable(rdata_o));

endmodule

// File: tb/endian_dmem_tb.sv
module endian_dmem_tb;

  localparam int ADDR_W = 8;
  localparam int NBYTES = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              big_endian_i = 1'b0;
  logic              req_i = 1'b0;
  logic              wr_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic [1:0]        size_i = 2'b00;
  logic              ld_signed_i = 1'b0;
  logic [31:0]       rdata_o;
  logic              err_o;

  always #10 clk = ~clk;

  endian_dmem #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i), .req_i(req_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .size_i(size_i), .ld_signed_i(ld_signed_i),
    .rdata_o(rdata_o), .err_o(err_o)
  );

  int tests = 0;
  int fails = 0;
  logic [7:0] mdl [NBYTES];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes_of(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
  endfunction

  function automatic logic misal(input logic [1:0] sz, input int a);
    int n = nbytes_of(sz);
    if (n == 0) return 1'b1;
    return (a % n) != 0;
  endfunction

  // model: value byte index held at address a+i
  function automatic int vbyte(input int i, input int n, input logic big);
    return big ? (n - 1 - i) : i;
  endfunction

  task automatic mdl_store(input logic [1:0] sz, input int a, input logic [31:0] v, input logic big);
    int n = nbytes_of(sz);
    if (misal(sz, a)) return;
    for (int i = 0; i < n; i++) mdl[a + i] = v[8*vbyte(i, n, big) +: 8];
  endtask

  function automatic logic [31:0] mdl_load(input logic [1:0] sz, input int a, input logic big,
                                           input logic sg);
    int n = nbytes_of(sz);
    logic [31:0] v = '0;
    logic top;
    if (misal(sz, a)) return 32'd0;
    for (int i = 0; i < n; i++) v[8*vbyte(i, n, big) +: 8] = mdl[a + i];
    top = v[8*n - 1];
    for (int b = 8*n; b < 32; b++) v[b] = sg & top;
    return v;
  endfunction

  // one request; results sampled at the falling edge after the capturing edge
  task automatic access(input logic wr, input logic [1:0] sz, input int a, input logic [31:0] wd,
                        input logic sg, input logic big, output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_i = 1'b1; wr_i = wr; size_i = sz; addr_i = ADDR_W'(a);
    wdata_i = wd; ld_signed_i = sg; big_endian_i = big;
    @(posedge clk);
    @(negedge clk);
    rd = rdata_o; er = err_o;
    req_i = 1'b0; wr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, held;
    logic er;
    logic [31:0] wd;
    string tag;

    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata_o, 32'd0);
    chk("R1 err in reset", {31'd0, err_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", rdata_o, 32'd0);
    chk("R1 err after reset", {31'd0, err_o}, 32'd0);

    // fill memory with a known pattern
    for (int w = 0; w < NBYTES / 4; w++) begin
      wd = 32'h1357_9BDF ^ (w * 32'h0102_0408);
      access(1'b1, 2'b10, 4*w, wd, 1'b0, 1'b0, rd, er);
      mdl_store(2'b10, 4*w, wd, 1'b0);
    end

    // R3 big-endian placement
    access(1'b1, 2'b10, 0, 32'h8765_4321, 1'b0, 1'b1, rd, er);
    mdl_store(2'b10, 0, 32'h8765_4321, 1'b1);
    access(1'b0, 2'b00, 0, 0, 1'b0, 1'b1, rd, er); chk("R3 byte@0", rd, 32'h87);
    access(1'b0, 2'b00, 1, 0, 1'b0, 1'b1, rd, er); chk("R3 byte@1", rd, 32'h65);
    access(1'b0, 2'b00, 2, 0, 1'b0, 1'b1, rd, er); chk("R3 byte@2", rd, 32'h43);
    access(1'b0, 2'b00, 3, 0, 1'b0, 1'b1, rd, er); chk("R3 byte@3", rd, 32'h21);

    // R4 little-endian placement
    access(1'b1, 2'b10, 4, 32'h8765_4321, 1'b0, 1'b0, rd, er);
    mdl_store(2'b10, 4, 32'h8765_4321, 1'b0);
    access(1'b0, 2'b00, 4, 0, 1'b0, 1'b0, rd, er); chk("R4 byte@4", rd, 32'h21);
    access(1'b0, 2'b00, 5, 0, 1'b0, 1'b0, rd, er); chk("R4 byte@5", rd, 32'h43);
    access(1'b0, 2'b00, 6, 0, 1'b0, 1'b0, rd, er); chk("R4 byte@6", rd, 32'h65);
    access(1'b0, 2'b00, 7, 0, 1'b0, 1'b0, rd, er); chk("R4 byte@7", rd, 32'h87);

    // sweep: endianness x size x offset x extension
    for (int be = 0; be < 2; be++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int off = 0; off < 4; off++) begin
          for (int sg = 0; sg < 2; sg++) begin
            int a = 64 + 16*sz + 4*off + off;
            logic bad;
            a = a - (a % 4) + off;
            bad = misal(2'(sz), a);
            tag = (sz == 0) ? "R5" : (sz == 1) ? "R6" : (sz == 2) ? "R2" : "R7";
            wd = 32'hF0A5_C38E ^ (32'(be) << 3) ^ (32'(off) * 32'h1111_0000) ^ (32'(sg) << 31);
            access(1'b1, 2'(sz), a, wd, 1'b0, 1'(be), rd, er);
            chk({"R7 store err ", tag}, {31'd0, er}, {31'd0, bad});
            mdl_store(2'(sz), a, wd, 1'(be));
            access(1'b0, 2'(sz), a, 0, 1'(sg), 1'(be), rd, er);
            chk({"R7 load err ", tag}, {31'd0, er}, {31'd0, bad});
            if (bad) chk("R8 bad load zero", rd, 32'd0);
            else if (sz < 2) chk(sg ? {tag, " R9 load"} : {tag, " R10 load"}, rd,
                                 mdl_load(2'(sz), a, 1'(be), 1'(sg)));
            else chk("R2 word load", rd, mdl_load(2'(sz), a, 1'(be), 1'(sg)));
            // whole-word readback proves untouched bytes kept (R5, R6, R8)
            access(1'b0, 2'b10, a - (a % 4), 0, 1'b0, 1'(be), rd, er);
            chk(bad ? "R8 word unchanged" : {tag, " word readback"}, rd,
                mdl_load(2'b10, a - (a % 4), 1'(be), 1'b0));
            chk("R7 aligned word no err", {31'd0, er}, 32'd0);
          end
        end
      end
    end

    // R9 / R10 with negative halfword and byte in both modes
    access(1'b1, 2'b01, 200, 32'h0000_8001, 1'b0, 1'b0, rd, er);
    mdl_store(2'b01, 200, 32'h0000_8001, 1'b0);
    access(1'b0, 2'b01, 200, 0, 1'b1, 1'b0, rd, er); chk("R9 half sext", rd, 32'hFFFF_8001);
    access(1'b0, 2'b01, 200, 0, 1'b0, 1'b0, rd, er); chk("R10 half zext", rd, 32'h0000_8001);
    access(1'b0, 2'b00, 201, 0, 1'b1, 1'b0, rd, er); chk("R9 byte sext", rd, 32'hFFFF_FF80);
    access(1'b0, 2'b00, 201, 0, 1'b0, 1'b0, rd, er); chk("R10 byte zext", rd, 32'h0000_0080);
    access(1'b0, 2'b01, 200, 0, 1'b1, 1'b1, rd, er); chk("R9 half sext big", rd, 32'h0000_0180);

    // R11 latency and hold across stores and idle cycles
    access(1'b0, 2'b10, 0, 0, 1'b0, 1'b1, rd, er);
    chk("R11 one-cycle load", rd, 32'h8765_4321);
    held = rd;
    access(1'b1, 2'b10, 8, 32'hDEAD_BEEF, 1'b0, 1'b1, rd, er);
    chk("R11 hold over store", rd, held);
    @(negedge clk); @(negedge clk);
    chk("R11 hold over idle", rdata_o, held);
    chk("R7 idle no err", {31'd0, err_o}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule